// File: doc/BRIEF.md
# Special-Register File with Zero, Flag and Program-Counter Entries

This block is the architectural register store of a small 16-bit processor. It holds eight entries selected by 3-bit codes. Three combinational read ports serve the destination/data field, the first-operand field and the second-operand field of an instruction. The destination port exists because a memory store takes its data from that field. A single write port commits results on the clock edge that ends an instruction.

Four of the eight codes behave in fixed ways:

- Code 000 is a constant zero.
- Code 101 holds the ALU flags and is filled only from a dedicated flag input.
- Code 110 is unused: it reads as zero and discards writes.
- Code 111 is the program counter. It can be read and written like any other entry, and it steps by one at the end of every instruction unless that instruction wrote it.

The surrounding decode logic marks each instruction's final cycle with a completion strobe. It raises the flag-load enable only when an ALU instruction actually executes, so a skipped conditional instruction leaves the flags alone.

Top module: `spcl_regfile`

## Requirements
- R1: After reset every entry, including the program counter and the flags, reads 0x0000 on all three read ports and on `pc_out`.
- R2: Code 000 reads 0x0000 on every read port, and a write to it is discarded.
- R3: Codes 001, 010, 011 and 100 return the last value written to them, and the read ports reflect the new value right after the write edge.
- R4: State changes only on a clock edge where `instr_done` is 1. With `instr_done` at 0, writes and flag loads are dropped and the program counter holds.
- R5: On an edge with `instr_done` and `flag_we` both 1, code 101 becomes `flag_in` in bits 3:0 with bits 15:4 cleared. Without `flag_we`, code 101 keeps its value.
- R6: A write-port write to code 101 is discarded, including when it coincides with a flag load.
- R7: Code 110 reads 0x0000 and discards writes.
- R8: On an edge with `instr_done` at 1 and no write to code 111, the program counter becomes its old value plus one, wrapping from 0xFFFF to 0x0000.
- R9: On an edge with `instr_done` at 1 and a write to code 111, the program counter takes `wr_data`, and no increment is applied.
- R10: The three read ports are independent. Any code on any port returns that entry's value, and `pc_out` always equals the value read at code 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_done | input | 1 | Marks the edge that ends an instruction |
| wr_en | input | 1 | Write-port enable |
| wr_sel | input | 3 | Write-port register code |
| wr_data | input | 16 | Write-port data |
| flag_we | input | 1 | Load the flag entry from `flag_in` |
| flag_in | input | 4 | ALU flags: V in bit 3, C in bit 2, N in bit 1, Z in bit 0 |
| rd_sel | input | 3 | Destination/data read code |
| ra_sel | input | 3 | First-operand read code |
| rb_sel | input | 3 | Second-operand read code |
| rd_data | output | 16 | Destination/data read value |
| ra_data | output | 16 | First-operand read value |
| rb_data | output | 16 | Second-operand read value |
| pc_out | output | 16 | Current program counter |

## Verification
The assertions check on every cycle that:

- the program counter either steps by one or takes the written value at each completion edge, and holds between completion edges;
- the flag entry changes only on a completion edge with the flag-load enable;
- code 000 and code 110 read zero;
- `pc_out` matches the code-111 read.

Only the bench's scenarios can show that values written to the general entries survive until read back. They also show that writes aimed at codes 000, 101 and 110 leave every port unchanged, and that a flag load coinciding with a write to code 101 yields the flag value. The bench sweeps all codes across all three ports, all sixteen flag patterns, and the 0xFFFF-to-zero wrap.

// File: rtl/spcl_regfile.sv
module spcl_regfile #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flag_we,
  input  logic [FLAG_W-1:0] flag_in,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [SEL_W-1:0]  ra_sel,
  input  logic [SEL_W-1:0]  rb_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  output logic [DATA_W-1:0] pc_out
);

  localparam int NUM_CODES = 2 ** SEL_W;
  localparam int GP_FIRST  = 1;
  localparam int GP_LAST   = 4;
  localparam int CODE_FLAG = 5;
  localparam int CODE_PC   = 7;

  logic [DATA_W-1:0] gp_q [GP_FIRST:GP_LAST];
  logic [FLAG_W-1:0] fl_q;
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] view [NUM_CODES];

  wire pc_write = wr_en && (wr_sel == SEL_W'(CODE_PC));

  for (genvar g = GP_FIRST; g <= GP_LAST; g++) begin : g_gp
    always_ff @(posedge clk) begin
      if (!rst_n)
        gp_q[g] <= '0;
      else if (instr_done && wr_en && (wr_sel == SEL_W'(g)))
        gp_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      fl_q <= '0;
    else if (instr_done && flag_we)
      fl_q <= flag_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pc_q <= '0;
    else if (instr_done)
      pc_q <= pc_write ? wr_data : pc_q + DATA_W'(1);
  end

  for (genvar v = 0; v < NUM_CODES; v++) begin : g_view
    if (v >= GP_FIRST && v <= GP_LAST) begin : g_gp_rd
      assign view[v] = gp_q[v];
    end else if (v == CODE_FLAG) begin : g_fl_rd
      assign view[v] = {{(DATA_W-FLAG_W){1'b0}}, fl_q};
    end else if (v == CODE_PC) begin : g_pc_rd
      assign view[v] = pc_q;
    end else begin : g_zero_rd
      assign view[v] = '0;
    end
  end

  assign rd_data = view[rd_sel];
  assign ra_data = view[ra_sel];
  assign rb_data = view[rb_sel];
  assign pc_out  = pc_q;

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && !(wr_en && wr_sel == SEL_W'(CODE_PC))) |=> (pc_out == $past(pc_out) + DATA_W'(1)));

  assert_pc_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && wr_en && wr_sel == SEL_W'(CODE_PC)) |=> (pc_out == $past(wr_data)));

  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |=> $stable(pc_out));

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_done && flag_we) |=> $stable(view[CODE_FLAG]));

  assert_flag_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && flag_we) |=> (view[CODE_FLAG] == DATA_W'($past(flag_in))));

  assert_zero_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_sel == '0) |-> (ra_data == '0));

  assert_unused_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_sel == SEL_W'(6)) |-> (rb_data == '0));

  assert_pc_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_W'(CODE_PC)) |-> (rd_data == pc_out));

endmodule

// File: tb/spcl_regfile_tb.sv
module spcl_regfile_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_done = 1'b0, wr_en = 1'b0, flag_we = 1'b0;
  logic [2:0] wr_sel = '0, rd_sel = '0, ra_sel = '0, rb_sel = '0;
  logic [15:0] wr_data = '0;
  logic [3:0] flag_in = '0;
  logic [15:0] rd_data, ra_data, rb_data, pc_out;

  logic [15:0] m [8];
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  spcl_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .flag_we(flag_we), .flag_in(flag_in),
    .rd_sel(rd_sel), .ra_sel(ra_sel), .rb_sel(rb_sel),
    .rd_data(rd_data), .ra_data(ra_data), .rb_data(rb_data), .pc_out(pc_out));

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 8; c++) begin
      rd_sel = 3'(c); ra_sel = 3'((c + 3) % 8); rb_sel = 3'((c + 5) % 8);
      #1;
      chk(req, $sformatf("rd port code %0d", c), rd_data, m[c]);
      chk(req, $sformatf("ra port code %0d", (c + 3) % 8), ra_data, m[(c + 3) % 8]);
      chk(req, $sformatf("rb port code %0d", (c + 5) % 8), rb_data, m[(c + 5) % 8]);
    end
    chk("R10", "pc_out", pc_out, m[7]);
  endtask

  task automatic step(input logic done, input logic we, input int sel, input logic [15:0] d,
                      input logic fwe, input logic [3:0] f);
    @(negedge clk);
    instr_done = done; wr_en = we; wr_sel = 3'(sel); wr_data = d; flag_we = fwe; flag_in = f;
    @(posedge clk);
    if (done) begin
      if (fwe) m[5] = {12'h000, f};
      if (we && sel >= 1 && sel <= 4) m[sel] = d;
      m[7] = (we && sel == 7) ? d : m[7] + 16'd1;
    end
    #5;
    instr_done = 1'b0; wr_en = 1'b0; flag_we = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    check_all("R1");

    for (int c = 0; c < 8; c++) begin
      step(1'b1, 1'b1, c, 16'h1000 * 16'(c) + 16'h00A5 + 16'(c), 1'b0, 4'h0);
      check_all(c == 0 ? "R2" : c == 5 ? "R6" : c == 6 ? "R7" : c == 7 ? "R9" : "R3");
    end

    for (int c = 1; c <= 4; c++) step(1'b1, 1'b1, c, ~(16'h0101 * 16'(c)), 1'b0, 4'h0);
    check_all("R3");

    step(1'b0, 1'b1, 2, 16'hDEAD, 1'b1, 4'hF);
    check_all("R4");
    step(1'b0, 1'b1, 7, 16'h4444, 1'b0, 4'h0);
    check_all("R4");

    for (int f = 0; f < 16; f++) begin
      step(1'b1, 1'b0, 0, 16'h0000, 1'b1, 4'(f));
      check_all("R5");
      step(1'b1, 1'b0, 0, 16'h0000, 1'b0, 4'(~f));
      check_all("R5");
    end

    step(1'b1, 1'b1, 5, 16'hFFFF, 1'b1, 4'h6);
    check_all("R6");
    step(1'b1, 1'b1, 5, 16'hFFF0, 1'b0, 4'h0);
    check_all("R6");

    step(1'b1, 1'b1, 7, 16'hFFFF, 1'b0, 4'h0);
    check_all("R9");
    step(1'b1, 1'b0, 7, 16'h1234, 1'b0, 4'h0);
    check_all("R8");
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 3, 16'(k * 77), 1'b0, 4'h0);
    check_all("R8");
    step(1'b1, 1'b1, 7, 16'h0040, 1'b1, 4'h9);
    check_all("R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule